// File: doc/BRIEF.md
# Prescaled Baud Tick Generator

This block produces the oversampling timebase for a serial transmitter and receiver pair. It divides the system clock by a 16-bit divisor that software loads one byte at a time. An optional fixed divide-by-4 stage can sit in front of the divisor. The output is a one-cycle enable pulse at sixteen times the wanted baud rate. The transmit side and the receive side both consume this same pulse, so one divisor sets the timing for both directions.

The divisor is chosen as `f_clk / (P * 16 * baud)`, where `P` is 1 or 4. For example, a 1.8432 MHz clock with `P = 1` needs a divisor of 12 for 9600 baud. Any divisor byte write takes effect at once: it reloads the down-counter and restarts the prescaler phase. First ticks after a reprogram therefore fall at a known time. A divisor of zero parks the generator, and no tick is produced.

The block carries no data stream. It has byte write strobes, a select level and a tick output, all plain control pins with no handshake and no back-pressure.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is zero and `baud_tick16` stays low until a nonzero divisor is written.
- R2: `div_lo_we` loads `wr_byte` into divisor bits 7:0 and `div_hi_we` loads it into bits 15:8. Both strobes may be high in one cycle, and then both bytes take the same value. The divisor holds its value in cycles with no strobe.
- R3: With `prescale_sel` = 0 and divisor D ≥ 1, `baud_tick16` is a one-cycle pulse repeating every D clock cycles.
- R4: With `prescale_sel` = 1 and divisor D ≥ 1, the pulse repeats every 4·D clock cycles, and two ticks never fall in consecutive cycles while the select stays high.
- R5: The divisor works at both ends of its range. D = 1 with select 0 holds the tick high every cycle, D = 1 with select 1 ticks every 4th cycle, and D = 65535 gives a period of 65535 cycles.
- R6: While the divisor is zero, whether from reset or from a later write, no tick is generated.
- R7: Any divisor byte write reloads the counter and restarts the prescaler. If a write is captured at clock edge w, the first tick is registered at edge w + P·D, with P = 1 for select 0 and P = 4 for select 1, and the counter never holds a value above the divisor.
- R8: When a write is captured at the same edge at which a tick would otherwise be registered, the write wins and no tick is produced at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_lo_we | input | 1 | Write strobe for divisor low byte |
| div_hi_we | input | 1 | Write strobe for divisor high byte |
| wr_byte | input | 8 | Byte value written by the strobes |
| prescale_sel | input | 1 | 1 selects the divide-by-4 prescaler, 0 divide-by-1 |
| baud_tick16 | output | 1 | One-cycle pulse at 16x the baud rate |

## Verification
A divisor write and a terminal count can land in the same clock cycle. In that cycle the reload must win and the tick that was due must vanish. The bench provokes this by aligning a low-byte write exactly on the edge where a tick is scheduled. It expects no pulse at that edge, and it expects the next pulses spaced by the new divisor counted from the write. Every pulse is compared against a scoreboard of expected edge numbers. Any pulse that is missing, or that has no matching entry, is a miscompare.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  localparam int unsigned DIV_WIDTH   = 16;
  localparam int unsigned LANE_WIDTH  = 8;
  localparam int unsigned PRESC_RATIO = 4;

  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_LOAD,
    ACT_STEP,
    ACT_WRAP
  } cnt_act_e;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned NLANES = DIV_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLANES-1:0] lane_we,
  input  logic [LANE_W-1:0] wr_byte,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_next,
  output logic              load
);
  assign load = |lane_we;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign div_next[g*LANE_W +: LANE_W] = lane_we[g] ? wr_byte : div_q[g*LANE_W +: LANE_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          div_q[g*LANE_W +: LANE_W] <= '0;
      else if (lane_we[g]) div_q[g*LANE_W +: LANE_W] <= wr_byte;
    end
  end

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(div_q));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned RATIO = 4,
  parameter int unsigned PW    = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_div,
  input  logic restart,
  output logic step_en
);
  if (RATIO > 1) begin : g_div
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
    logic [PW-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              phase <= '0;
      else if (restart)        phase <= '0;
      else if (phase == LAST)  phase <= '0;
      else                     phase <= phase + 1'b1;
    end

    assign step_en = sel_div ? (phase == LAST) : 1'b1;

    // R4
    presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_div && step_en && !restart) |=> (!step_en || !sel_div));
  end else begin : g_pass
    assign step_en = 1'b1;
  end
endmodule

// File: rtl/baud_count.sv
module baud_count
  import baudgen_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] div_cur,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  cnt_act_e         act;

  always_comb begin
    if (load)                        act = ACT_LOAD;
    else if (!step_en)               act = ACT_IDLE;
    else if (div_cur == '0)          act = ACT_IDLE;
    else if (cnt <= DIV_W'(1))       act = ACT_WRAP;
    else                             act = ACT_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (act == ACT_WRAP);
      unique case (act)
        ACT_LOAD: cnt <= load_val;
        ACT_WRAP: cnt <= div_cur;
        ACT_STEP: cnt <= cnt - 1'b1;
        default:  cnt <= cnt;
      endcase
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= div_cur);

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tick);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baudgen_pkg::*;
#(
  parameter int unsigned DIV_W  = DIV_WIDTH,
  parameter int unsigned LANE_W = LANE_WIDTH,
  parameter int unsigned RATIO  = PRESC_RATIO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_lo_we,
  input  logic              div_hi_we,
  input  logic [LANE_W-1:0] wr_byte,
  input  logic              prescale_sel,
  output logic              baud_tick16
);
  localparam int unsigned NLANES = DIV_W / LANE_W;

  logic [NLANES-1:0] lane_we;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  div_next;
  logic              load;
  logic              step_en;

  always_comb begin
    lane_we    = '0;
    lane_we[0] = div_lo_we;
    lane_we[NLANES-1] = lane_we[NLANES-1] | div_hi_we;
  end

  baud_div_regs #(.DIV_W(DIV_W), .LANE_W(LANE_W), .NLANES(NLANES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_we  (lane_we),
    .wr_byte  (wr_byte),
    .div_q    (div_q),
    .div_next (div_next),
    .load     (load)
  );

  baud_prescaler #(.RATIO(RATIO)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_div (prescale_sel),
    .restart (load),
    .step_en (step_en)
  );

  baud_count #(.DIV_W(DIV_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .load     (load),
    .load_val (div_next),
    .div_cur  (div_q),
    .tick     (baud_tick16)
  );

  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && !load) |=> !baud_tick16);

  // R3
  tick_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick16 |-> $past(step_en));
endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_lo_we = 1'b0;
  logic       div_hi_we = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       prescale_sel = 1'b0;
  logic       baud_tick16;

  int    cyc = 0;
  int    vec = 0;
  int    bad = 0;
  int    stray = 0;
  int    exp_q[$];
  string tag_q[$];
  string cur_tag = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  baud_tick_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .div_lo_we    (div_lo_we),
    .div_hi_we    (div_hi_we),
    .wr_byte      (wr_byte),
    .prescale_sel (prescale_sel),
    .baud_tick16  (baud_tick16)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        vec++;
        if (baud_tick16 !== 1'b1) begin
          bad++;
          $display("FAIL %s: tick at edge %0d actual %b expected 1", tag_q[0], cyc, baud_tick16);
        end
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end else if (baud_tick16 !== 1'b0) begin
        vec++; bad++; stray++;
        $display("FAIL %s: tick at edge %0d actual %b expected 0", cur_tag, cyc, baud_tick16);
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    bad++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  task automatic wr_at(input int t, input bit lo, input bit hi, input logic [7:0] d, output int w);
    while (cyc < t - 1) @(negedge clk);
    div_lo_we = lo; div_hi_we = hi; wr_byte = d;
    @(negedge clk);
    w = cyc;
    div_lo_we = 1'b0; div_hi_we = 1'b0;
  endtask

  task automatic push_ticks(input int w, input int period, input int k, input string tag);
    for (int i = 1; i <= k; i++) begin
      exp_q.push_back(w + period * i);
      tag_q.push_back(tag);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // hi then lo write; returns edge of lo write
  task automatic prog_div(input logic [7:0] hi, input logic [7:0] lo, input bit sel,
                          input int k, input string tag, output int w);
    int wh;
    int d;
    int p;
    cur_tag = tag;
    prescale_sel = sel;
    wr_at(cyc + 1, 1'b0, 1'b1, hi, wh);
    wr_at(cyc + 1, 1'b1, 1'b0, lo, w);
    d = {hi, lo};
    p = sel ? 4 : 1;
    push_ticks(w, p * d, k, tag);
    wait_to(w + p * d * k);
  endtask

  task automatic quiet(input int n, input string tag);
    int s0;
    s0 = stray;
    cur_tag = tag;
    repeat (n) @(negedge clk);
    vec++;
    if (stray != s0) begin
      bad++;
      $display("FAIL %s: stray ticks actual %0d expected 0", tag, stray - s0);
    end
  endtask

  initial begin
    int w;
    int w2;
    repeat (4) @(negedge clk);
    vec++;
    if (baud_tick16 !== 1'b0) begin
      bad++;
      $display("FAIL R1: tick in reset actual %b expected 0", baud_tick16);
    end
    rst_n = 1'b1;
    @(negedge clk);
    quiet(30, "R1");

    prog_div(8'h00, 8'd12, 1'b0, 5, "R3", w);
    prog_div(8'h00, 8'd5, 1'b1, 4, "R4", w);
    prog_div(8'h00, 8'd1, 1'b0, 8, "R5", w);
    prog_div(8'h00, 8'd1, 1'b1, 4, "R5", w);
    prog_div(8'h01, 8'h03, 1'b0, 2, "R2", w);

    // both strobes in one cycle: divisor 0x0202
    cur_tag = "R2";
    wr_at(cyc + 1, 1'b1, 1'b1, 8'h02, w);
    push_ticks(w, 514, 2, "R2");
    wait_to(w + 1028);

    // R7: reload mid-count restarts timing
    prog_div(8'h00, 8'd50, 1'b0, 0, "R7", w);
    wait_to(w + 20);
    wr_at(w + 21, 1'b1, 1'b0, 8'd7, w2);
    push_ticks(w2, 7, 3, "R7");
    wait_to(w2 + 21);

    // R7 with prescaler phase restart
    prog_div(8'h00, 8'd3, 1'b1, 2, "R7", w);

    // R8: write lands on a due tick
    prog_div(8'h00, 8'd3, 1'b0, 1, "R8", w);
    cur_tag = "R8";
    wr_at(w + 6, 1'b1, 1'b0, 8'd2, w2);
    vec++;
    if (w2 != w + 6 || baud_tick16 !== 1'b0) begin
      bad++;
      $display("FAIL R8: tick at collision edge actual %b expected 0", baud_tick16);
    end
    push_ticks(w2, 2, 2, "R8");
    wait_to(w2 + 4);

    // R6: zero divisor written while running
    prog_div(8'h00, 8'd0, 1'b0, 0, "R6", w);
    quiet(150, "R6");
    prog_div(8'h00, 8'd0, 1'b1, 0, "R6", w);
    quiet(100, "R6");

    // R5: top of range
    prog_div(8'hFF, 8'hFF, 1'b0, 1, "R5", w);
    cur_tag = "R5";
    wr_at(cyc + 1, 1'b1, 1'b1, 8'h00, w);
    quiet(20, "R6");

    vec++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R3: pending ticks actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end
endmodule